// File: doc/BRIEF.md
# Double-Buffered Byte Serial Port (Master or Slave)

This block is a byte-wide synchronous serial port for a processor-side register bus. A control bit makes it either the clock-generating master or a slave clocked by an external serial clock and qualified by an active-low select. Software writes a byte into a one-deep transmit buffer. The buffer moves into the shift register as soon as the shifter is free. Each received byte lands in a receive holding register, so one byte can be shifted while software handles the previous one.

Two registers sit on a one-bit address. The control/status register carries the role bit, a two-bit clock-rate field and three read-only flags: transmit buffer empty, receive full and receive overflow. The data register feeds the transmit buffer on writes and returns the receive holding register on reads. Both flags that report received data clear only through a fixed access order: a status read that sees a flag set, followed by a data read. The serial format is fixed. The clock idles low, data is sampled on the rising edge and changes after the falling edge, and the most significant bit goes first.

Top module: `spi_duplex_port`

## Requirements
- R1: After reset the status register reads 0x40: slave role, rate 00, transmit-empty (bit 6) set, receive-full (bit 7) and overflow (bit 5) clear. `sck_o` is low.
- R2: Address 0 is control/status: bit 0 is the role (1 = master), bits 2:1 are the rate, and bits 7, 6 and 5 are the read-only flags. Address 1 is data. `bus_rdata` holds the selected value in the cycle after the read strobe.
- R3: A data write clears transmit-empty in the next cycle. If the shifter is free, the byte moves into it one cycle later and transmit-empty sets again.
- R4: In master mode a data write starts a transfer of exactly eight `sck_o` pulses, with the clock idling low. `sdo` presents the bytes MSB first, and each bit is stable at the rising edge.
- R5: Rate codes 00, 01, 10 and 11 give `sck_o` high and low phases of 1, 4, 16 and 64 system clocks each, which is clk/2, /8, /32 and /128.
- R6: `sdi` is sampled on every rising serial-clock edge while `sdo` shifts out. On the eighth rising edge the assembled byte is copied into the receive register and receive-full sets.
- R7: Receive-full clears only when a status read that sees it set is followed by a data read. A data read on its own leaves it set.
- R8: In slave mode `sck_o` stays low and shifting follows `sck_i` only while `sel_n` is low. Raising `sel_n` before the eighth bit discards the partial byte without setting receive-full.
- R9: In slave mode a byte written beforehand is shifted out on `sdo` MSB first, one bit per `sck_i` period.
- R10: If a byte completes while receive-full is still set, overflow (bit 5) sets and the receive register keeps its old byte. Overflow clears by the same status-then-data sequence.
- R11: A data write made while the shifter is busy is held in the buffer. Transmit-empty stays clear until the current byte finishes, and then that byte is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = control/status, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sck_o | output | 1 | Serial clock generated in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| sel_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |

## Verification
On every cycle the assertions check several local properties. The serial clock stays silent after a cycle in slave role. Receive-full survives any cycle without a data read. Overflow can only appear while receive-full is set, and the receive register holds steady when a byte arrives on top of an unread one. A data write always drops transmit-empty. The bench scenarios cover what needs whole transfers to show. These are the received byte and bit order under each rate, the phase lengths of the generated clock, the buffered second write and its overflow, the order of the flag-clearing sequence, and slave transfers with a select released partway through a byte.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;
  localparam int BYTE_W  = 8;
  localparam int RATE_W  = 2;
  localparam int DIV_W   = 2 * ((1 << RATE_W) - 1) + 1;
  localparam int BITC_W  = $clog2(BYTE_W + 1);
  localparam int SYNC_N  = 3;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  localparam int CB_MASTER = 0;
  localparam int CB_RATE   = 1;
  localparam int SB_OVF    = 5;
  localparam int SB_TXE    = 6;
  localparam int SB_RXF    = 7;

  // half period minus one, in system clocks: 4**rate - 1
  function automatic logic [DIV_W-1:0] half_m1(input logic [RATE_W-1:0] rate);
    logic [DIV_W-1:0] one;
    one = {{(DIV_W-1){1'b0}}, 1'b1};
    return (one << (2 * rate)) - one;
  endfunction
endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_duplex_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              sck,
  output logic              rise_stb,
  output logic              fall_stb
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap     = (cnt == half_m1(rate));
  assign rise_stb = run && wrap && !sck;
  assign fall_stb = run && wrap && sck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      sck <= !sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_duplex_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              master,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              m_rise,
  input  logic              m_fall,
  input  logic              sck_i,
  input  logic              sel_n,
  input  logic              sdi,
  output logic              idle,
  output logic              busy,
  output logic              sdo,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [SYNC_N-1:0] sck_s;
  logic [SYNC_N-2:0] sel_s;
  logic [BYTE_W-1:0] txsh, tx_hold, rxsh;
  logic [BITC_W-1:0] cnt;
  logic s_act, s_rise, s_fall, rise, fall, last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s <= '0;
      sel_s <= '1;
    end else begin
      sck_s <= {sck_s[SYNC_N-2:0], sck_i};
      sel_s <= {sel_s[SYNC_N-3:0], sel_n};
    end
  end

  assign s_act  = !sel_s[SYNC_N-2];
  assign s_rise = s_act && sck_s[SYNC_N-2] && !sck_s[SYNC_N-1];
  assign s_fall = s_act && !sck_s[SYNC_N-2] && sck_s[SYNC_N-1];
  assign rise   = master ? m_rise : s_rise;
  assign fall   = master ? m_fall : s_fall;
  assign last   = (cnt == BITC_W'(BYTE_W - 1));
  assign idle   = !busy && (cnt == '0);
  assign sdo    = txsh[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      txsh    <= '0;
      tx_hold <= '0;
      rxsh    <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        txsh    <= load_data;
        tx_hold <= load_data;
        busy    <= 1'b1;
        cnt     <= '0;
      end else if (!master && !s_act) begin
        cnt  <= '0;
        txsh <= tx_hold;
      end else if (rise) begin
        rxsh <= {rxsh[BYTE_W-2:0], sdi};
        if (last) begin
          done    <= 1'b1;
          rx_byte <= {rxsh[BYTE_W-2:0], sdi};
          if (!master) begin
            busy <= 1'b0;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (fall) begin
        if (master && cnt == BITC_W'(BYTE_W)) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else if (cnt != '0) begin
          txsh <= {txsh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_duplex_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              shf_idle,
  input  logic              rx_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              load,
  output logic [BYTE_W-1:0] tx_buf,
  output logic              master,
  output logic [RATE_W-1:0] rate,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              ovf,
  output logic [BYTE_W-1:0] rx_data
);
  logic buf_full, armed;
  logic wr_data, wr_ctrl, rd_stat, rd_data, clr, full_eff;
  logic [BYTE_W-1:0] status;

  assign wr_data  = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
  assign rd_data  = bus_rd && (bus_addr == ADDR_DATA);
  assign rd_stat  = bus_rd && (bus_addr == ADDR_CTRL);
  assign clr      = rd_data && armed;
  assign full_eff = rx_full && !clr;
  assign load     = buf_full && shf_idle;

  always_comb begin
    status            = '0;
    status[CB_MASTER] = master;
    status[CB_RATE +: RATE_W] = rate;
    status[SB_OVF]    = ovf;
    status[SB_TXE]    = tx_empty;
    status[SB_RXF]    = rx_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      master    <= 1'b0;
      rate      <= '0;
      tx_buf    <= '0;
      buf_full  <= 1'b0;
      tx_empty  <= 1'b1;
      rx_full   <= 1'b0;
      ovf       <= 1'b0;
      armed     <= 1'b0;
      rx_data   <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        master <= bus_wdata[CB_MASTER];
        rate   <= bus_wdata[CB_RATE +: RATE_W];
      end
      if (wr_data) begin
        tx_buf   <= bus_wdata;
        buf_full <= 1'b1;
        tx_empty <= 1'b0;
      end else if (load) begin
        buf_full <= 1'b0;
        tx_empty <= 1'b1;
      end
      if (rd_stat && (rx_full || ovf)) armed <= 1'b1;
      else if (rd_data)                armed <= 1'b0;
      if (rx_done && !full_eff) begin
        rx_data <= rx_byte;
        rx_full <= 1'b1;
      end else if (clr) begin
        rx_full <= 1'b0;
      end
      if (rx_done && full_eff) ovf <= 1'b1;
      else if (clr)            ovf <= 1'b0;
      if (bus_rd) bus_rdata <= rd_data ? rx_data : status;
    end
  end
endmodule

// File: rtl/spi_duplex_port.sv
module spi_duplex_port
  import spi_duplex_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              sck_o,
  input  logic              sck_i,
  input  logic              sel_n,
  input  logic              sdi,
  output logic              sdo
);
  logic              ctrl_master, tx_empty, rx_full, ovf_flag, xfer_done;
  logic              shf_idle, shf_busy, load, m_rise, m_fall;
  logic [RATE_W-1:0] rate;
  logic [BYTE_W-1:0] tx_buf, rx_byte, rx_data;

  spi_regs u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .shf_idle(shf_idle), .rx_done(xfer_done), .rx_byte(rx_byte),
    .load(load), .tx_buf(tx_buf), .master(ctrl_master), .rate(rate),
    .tx_empty(tx_empty), .rx_full(rx_full), .ovf(ovf_flag), .rx_data(rx_data)
  );

  spi_sck_gen u_sck (
    .clk(clk), .rst(rst), .run(shf_busy && ctrl_master), .rate(rate),
    .sck(sck_o), .rise_stb(m_rise), .fall_stb(m_fall)
  );

  spi_shift_engine u_shf (
    .clk(clk), .rst(rst), .master(ctrl_master), .load(load),
    .load_data(tx_buf), .m_rise(m_rise), .m_fall(m_fall),
    .sck_i(sck_i), .sel_n(sel_n), .sdi(sdi), .idle(shf_idle),
    .busy(shf_busy), .sdo(sdo), .done(xfer_done), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/spi_duplex_port_chk.sv
module spi_duplex_port_chk
  import spi_duplex_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_addr,
  input logic              master,
  input logic              sck_o,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              ovf,
  input logic              done,
  input logic [BYTE_W-1:0] rx_data
);
  AST_SCK_QUIET_SLAVE: assert property (@(posedge clk) disable iff (rst)
    !master |=> !sck_o); // R8
  AST_RXF_HOLD: assert property (@(posedge clk) disable iff (rst)
    rx_full && !(bus_rd && bus_addr == ADDR_DATA) |=> rx_full); // R7
  AST_OVF_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    !rx_full && !ovf |=> !ovf); // R10
  AST_RX_KEPT: assert property (@(posedge clk) disable iff (rst)
    rx_full && done && !(bus_rd && bus_addr == ADDR_DATA) |=> $stable(rx_data)); // R10
  AST_TXE_DROP: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_addr == ADDR_DATA |=> !tx_empty); // R3
endmodule

bind spi_duplex_port spi_duplex_port_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .master(ctrl_master), .sck_o(sck_o), .tx_empty(tx_empty), .rx_full(rx_full),
  .ovf(ovf_flag), .done(xfer_done), .rx_data(rx_data)
);

// File: tb/spi_duplex_port_test.sv
module spi_duplex_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sck_o, sdo, sdi;
  logic       sck_i = 1'b0, sel_n = 1'b1, tb_sdi = 1'b0;
  logic       slave_drv = 1'b0, inv = 1'b0;
  int         checks = 0, errors = 0;
  bit         finished = 1'b0;

  always #5 clk = !clk;

  always_comb sdi = slave_drv ? tb_sdi : (inv ? !sdo : sdo);

  spi_duplex_port uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o), .sck_i(sck_i),
    .sel_n(sel_n), .sdi(sdi), .sdo(sdo)
  );

  // serial clock observer
  logic       sck_prev = 1'b0;
  logic [7:0] cap = '0;
  int         hi_run = 0, last_hi = 0, rise_cnt = 0;
  always @(negedge clk) begin
    if (sck_o && !sck_prev) begin
      cap <= {cap[6:0], sdo};
      hi_run <= 1;
      rise_cnt <= rise_cnt + 1;
    end else if (sck_o) begin
      hi_run <= hi_run + 1;
    end
    if (!sck_o && sck_prev) last_hi <= hi_run;
    sck_prev <= sck_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_rxf(output logic [7:0] st);
    st = '0;
    for (int i = 0; i < 4000; i++) begin
      rd(1'b0, st);
      if (st[7]) break;
    end
  endtask

  task automatic slv_xfer(input logic [7:0] mo, input int nbits, output logic [7:0] so);
    so = '0;
    sel_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      tb_sdi = mo[7-i];
      repeat (8) @(negedge clk);
      so = {so[6:0], sdo};
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    sel_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // {rate, invert, tx}
  localparam logic [10:0] VEC [8] = '{
    {2'd0, 1'b0, 8'hA5}, {2'd1, 1'b1, 8'h3C}, {2'd2, 1'b0, 8'h81},
    {2'd3, 1'b1, 8'h7E}, {2'd0, 1'b1, 8'h00}, {2'd0, 1'b0, 8'hFF},
    {2'd1, 1'b0, 8'h5A}, {2'd2, 1'b1, 8'hC3}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, d, so;
    int r0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd(1'b0, st);
    chk(st == 8'h40, "R1 reset status", st, 8'h40);
    chk(sck_o == 1'b0, "R1 sck idle", sck_o, 0);

    wr(1'b0, 8'h05);
    rd(1'b0, st);
    chk(st[2:0] == 3'b101, "R2 control readback", st[2:0], 3'b101);

    for (int v = 0; v < 8; v++) begin
      logic [1:0] rate;
      logic [7:0] tx, exp;
      rate = VEC[v][10:9];
      inv  = VEC[v][8];
      tx   = VEC[v][7:0];
      exp  = inv ? ~tx : tx;
      wr(1'b0, {5'd0, rate, 1'b1});
      r0 = rise_cnt;
      wr(1'b1, tx);
      wait_rxf(st);
      rd(1'b1, d);
      chk(d == exp, "R6 received byte", d, exp);
      chk(cap == tx, "R4 MSB-first sdo", cap, tx);
      chk(rise_cnt - r0 == 8, "R4 pulse count", rise_cnt - r0, 8);
      chk(last_hi == (1 << (2 * rate)), "R5 phase length", last_hi, 1 << (2 * rate));
      repeat (300) @(negedge clk);
      rd(1'b0, st);
      chk(st[7] == 1'b0, "R7 flag cleared by sequence", st[7], 0);
    end

    // buffered second write and overflow
    inv = 1'b0;
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h11);
    rd(1'b0, st);
    chk(st[6] == 1'b1, "R3 byte moved, empty again", st[6], 1);
    wr(1'b1, 8'h22);
    rd(1'b0, st);
    chk(st[6] == 1'b0, "R11 empty held clear while busy", st[6], 0);
    repeat (100) @(negedge clk);
    rd(1'b1, d);
    chk(d == 8'h11, "R10 first byte kept", d, 8'h11);
    rd(1'b0, st);
    chk(st[7] && st[5], "R7 data read alone keeps flags", st[7:5], 3'b111);
    chk(st[6] == 1'b1, "R11 second byte sent", st[6], 1);
    rd(1'b1, d);
    chk(d == 8'h11, "R10 overflowing byte discarded", d, 8'h11);
    rd(1'b0, st);
    chk(st[7:5] == 3'b010, "R10 overflow cleared by sequence", st[7:5], 3'b010);

    // slave mode
    repeat (50) @(negedge clk);
    wr(1'b0, 8'h00);
    slave_drv = 1'b1;
    r0 = rise_cnt;
    wr(1'b1, 8'h96);
    slv_xfer(8'h3B, 8, so);
    chk(so == 8'h96, "R9 slave sdo", so, 8'h96);
    rd(1'b0, st);
    chk(st[7] == 1'b1, "R8 slave byte sets full", st[7], 1);
    rd(1'b1, d);
    chk(d == 8'h3B, "R8 slave received", d, 8'h3B);
    slv_xfer(8'hF0, 3, so);
    rd(1'b0, st);
    chk(st[7] == 1'b0, "R8 aborted byte ignored", st[7], 0);
    slv_xfer(8'hC4, 8, so);
    rd(1'b0, st);
    rd(1'b1, d);
    chk(d == 8'hC4, "R8 realigned after abort", d, 8'hC4);
    chk(rise_cnt == r0, "R8 sck_o silent in slave", rise_cnt - r0, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule